// File: doc/BRIEF.md
# Vector-Indexed Address Generator

This block forms the memory addresses for a gather-style operand. The operand's index is a whole vector register, not a single scalar. From the 2-bit mod field, the SIB byte and the two prefix extension bits, it works out three things: which general register serves as the base, which vector register supplies the indices, and which displacement applies. It reads the base through a combinational read port into a 16-entry general register file. It then produces one effective address per lane, with all lanes computed in parallel: each signed 32-bit index element is sign-extended, scaled, and added to the base and the displacement.

The results are registered. They appear with `out_valid` one cycle after `in_valid`. In 32-bit mode only the low half of the base is used, and every address wraps modulo 2^32. A mod value of 11b is an illegal encoding for this operand, and it is flagged on `bad_enc`. The memory access itself, fault handling and lane masking happen elsewhere.

Top module: `vsib_agen`

## Requirements
- R1: The scale field `sib[7:6]` multiplies every sign-extended lane index by 1, 2, 4 or 8 (encodings 00b, 01b, 10b and 11b).
- R2: In 64-bit mode, `index_sel` is {`ext_x`, `sib[5:3]`} and `base_sel` is {`ext_b`, `sib[2:0]`}. In 32-bit mode the top bit of both selectors is 0. `gpr_rd_addr` carries the base selector.
- R3: When mod=00b and `sib[2:0]`=101b, each lane's address is the scaled index plus the sign-extended 32-bit `disp`, and no base register is added.
- R4: When mod=01b, each lane's address is the base register plus the scaled index plus the sign-extended `disp[7:0]`. `disp[31:8]` has no effect.
- R5: When mod=10b, each lane's address is the base register plus the scaled index plus the sign-extended 32-bit `disp`.
- R6: When mod=00b and the base field is not 101b, each lane's address is the base register plus the scaled index, and `disp` has no effect.
- R7: When `long_mode`=1, the full 64-bit base value is used. When `long_mode`=0, only base bits [31:0] are used, and each address is reduced modulo 2^32 with bits [63:32] zero.
- R8: A valid input with mod=11b produces `out_valid`=1 and `bad_enc`=1 one cycle later, and all lane addresses are 0.
- R9: `out_valid` is `in_valid` delayed by one cycle. When `in_valid` is 0, the registered selectors, addresses and `bad_enc` keep their values. Lane k occupies `lane_addr[64k+63:64k]` and takes its index from `vidx[32k+31:32k]`.
- R10: After reset, `out_valid`, `bad_enc`, the selectors and all lane addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand fields are valid this cycle |
| mod_f | input | 2 | mod field |
| sib | input | 8 | scale[7:6], index[5:3], base[2:0] |
| ext_x | input | 1 | Prefix extension bit for the index selector |
| ext_b | input | 1 | Prefix extension bit for the base selector |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| disp | input | 32 | Displacement; only [7:0] is used for mod=01b |
| gpr_rd_addr | output | 4 | General register file read address |
| gpr_rd_data | input | 64 | Read data for gpr_rd_addr, same cycle |
| vidx | input | 256 | Lanes of the selected vector index register, 32 bits each |
| out_valid | output | 1 | Registered results are valid |
| bad_enc | output | 1 | Illegal encoding (mod=11b) |
| base_sel | output | 4 | Registered base register number |
| index_sel | output | 4 | Registered vector index register number |
| lane_addr | output | 512 | Eight 64-bit per-lane addresses |

## Verification
The assertions assume that `gpr_rd_data` settles within the same cycle as `gpr_rd_addr`. They also assume that `mode`, `sib` and the extension bits are known whenever `in_valid` is high. The bench models the register file combinationally from its own array, so the first assumption holds. It drives every field from an initial block on the falling edge, and it holds `in_valid` low between operations. This keeps the stable-hold property and the 32-bit upper-half property within the one-cycle windows they describe.

// File: rtl/vsib_pkg.sv
package vsib_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DISP_W = 32;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic [1:0] {
    MOD_NODISP = 2'b00,
    MOD_DISP8  = 2'b01,
    MOD_DISP32 = 2'b10,
    MOD_REG    = 2'b11
  } mod_e;

  typedef struct packed {
    logic [SEL_W-1:0]  base_sel;
    logic [SEL_W-1:0]  idx_sel;
    logic              use_base;
    logic [ADDR_W-1:0] disp_ext;
    logic              bad;
  } dec_t;
endpackage

// File: rtl/vsib_decode.sv
module vsib_decode
  import vsib_pkg::*;
(
  input  logic [1:0]        mod_f,
  input  logic [7:0]        sib,
  input  logic              ext_x,
  input  logic              ext_b,
  input  logic              long_mode,
  input  logic [DISP_W-1:0] disp,
  output dec_t              dec
);
  mod_e mode;
  logic no_base;

  always_comb begin
    mode     = mod_e'(mod_f);
    no_base  = (mode == MOD_NODISP) && (sib[2:0] == 3'b101);
    dec.base_sel = {ext_b & long_mode, sib[2:0]};
    dec.idx_sel  = {ext_x & long_mode, sib[5:3]};
    dec.use_base = !no_base;
    dec.bad      = (mode == MOD_REG);
    unique case (mode)
      MOD_DISP8:  dec.disp_ext = {{(ADDR_W-8){disp[7]}}, disp[7:0]};
      MOD_DISP32: dec.disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      MOD_NODISP: dec.disp_ext = no_base ? {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp}
                                         : '0;
      default:    dec.disp_ext = '0;
    endcase
  end
endmodule

// File: rtl/vsib_lane.sv
module vsib_lane
  import vsib_pkg::*;
#(
  parameter int unsigned IDX_W = 32
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        scale,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] disp_ext,
  input  logic              long_mode,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    idx_ext = {{(ADDR_W-IDX_W){idx[IDX_W-1]}}, idx};
    scaled  = idx_ext << scale;
    sum     = base_val + scaled + disp_ext;
    addr    = long_mode ? sum : {{(ADDR_W-32){1'b0}}, sum[31:0]};
  end
endmodule

// File: rtl/vsib_agen.sv
module vsib_agen
  import vsib_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned IDX_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              mod_f,
  input  logic [7:0]              sib,
  input  logic                    ext_x,
  input  logic                    ext_b,
  input  logic                    long_mode,
  input  logic [DISP_W-1:0]       disp,
  output logic [SEL_W-1:0]        gpr_rd_addr,
  input  logic [ADDR_W-1:0]       gpr_rd_data,
  input  logic [LANES*IDX_W-1:0]  vidx,
  output logic                    out_valid,
  output logic                    bad_enc,
  output logic [SEL_W-1:0]        base_sel,
  output logic [SEL_W-1:0]        index_sel,
  output logic [LANES*ADDR_W-1:0] lane_addr
);
  localparam int unsigned HALF_W = ADDR_W / 2;

  dec_t              dec;
  logic [ADDR_W-1:0] base_val;
  logic [ADDR_W-1:0] lane_d [LANES];
  logic [ADDR_W-1:0] addr_q [LANES];
  logic [ADDR_W-1:0] addr_n [LANES];
  logic [SEL_W-1:0]  bsel_q, bsel_n, isel_q, isel_n;
  logic              vld_q, bad_q, bad_n;

  vsib_decode u_dec (
    .mod_f(mod_f), .sib(sib), .ext_x(ext_x), .ext_b(ext_b),
    .long_mode(long_mode), .disp(disp), .dec(dec)
  );

  assign gpr_rd_addr = dec.base_sel;

  always_comb begin
    if (!dec.use_base)  base_val = '0;
    else if (long_mode) base_val = gpr_rd_data;
    else                base_val = {{HALF_W{1'b0}}, gpr_rd_data[HALF_W-1:0]};
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vsib_lane #(.IDX_W(IDX_W)) u_lane (
      .idx(vidx[k*IDX_W +: IDX_W]), .scale(sib[7:6]), .base_val(base_val),
      .disp_ext(dec.disp_ext), .long_mode(long_mode), .addr(lane_d[k])
    );
    assign lane_addr[k*ADDR_W +: ADDR_W] = addr_q[k];
  end

  // next state: capture only when in_valid (clock enable written out)
  always_comb begin
    bsel_n = bsel_q;
    isel_n = isel_q;
    bad_n  = bad_q;
    for (int k = 0; k < LANES; k++) addr_n[k] = addr_q[k];
    if (in_valid) begin
      bsel_n = dec.base_sel;
      isel_n = dec.idx_sel;
      bad_n  = dec.bad;
      for (int k = 0; k < LANES; k++) addr_n[k] = dec.bad ? '0 : lane_d[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      bad_q  <= 1'b0;
      bsel_q <= '0;
      isel_q <= '0;
      for (int k = 0; k < LANES; k++) addr_q[k] <= '0;
    end else begin
      vld_q  <= in_valid;
      bad_q  <= bad_n;
      bsel_q <= bsel_n;
      isel_q <= isel_n;
      for (int k = 0; k < LANES; k++) addr_q[k] <= addr_n[k];
    end
  end

  assign out_valid = vld_q;
  assign bad_enc   = bad_q;
  assign base_sel  = bsel_q;
  assign index_sel = isel_q;

  // R8
  bad_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_f == 2'b11) |=> (out_valid && bad_enc && lane_addr == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(lane_addr) && $stable(base_sel) && $stable(bad_enc)));

  // R2
  narrow_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !long_mode) |=> (!base_sel[SEL_W-1] && !index_sel[SEL_W-1]));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // R7
    wrap32_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !long_mode) |=> (lane_addr[k*ADDR_W+HALF_W +: HALF_W] == '0));
  end
endmodule

// File: tb/sim_vsib_agen.sv
module sim_vsib_agen;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] mod_f = '0;
  logic [7:0] sib = '0;
  logic ext_x = 1'b0, ext_b = 1'b0, long_mode = 1'b0;
  logic [31:0] disp = '0;
  logic [3:0] gpr_rd_addr;
  logic [63:0] gpr_rd_data;
  logic [LANES*32-1:0] vidx = '0;
  logic out_valid, bad_enc;
  logic [3:0] base_sel, index_sel;
  logic [LANES*64-1:0] lane_addr;

  logic [63:0] gpr [16];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign gpr_rd_data = gpr[gpr_rd_addr];

  vsib_agen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mod_f(mod_f), .sib(sib),
    .ext_x(ext_x), .ext_b(ext_b), .long_mode(long_mode), .disp(disp),
    .gpr_rd_addr(gpr_rd_addr), .gpr_rd_data(gpr_rd_data), .vidx(vidx),
    .out_valid(out_valid), .bad_enc(bad_enc), .base_sel(base_sel),
    .index_sel(index_sel), .lane_addr(lane_addr)
  );

  // {mod[52:51], sib[50:43], x[42], b[41], lm[40], disp[39:8], seed[7:0]}
  localparam logic [52:0] TAB [NV] = '{
    {2'd0, 8'h08, 1'b0, 1'b0, 1'b1, 32'h0000_1234, 8'd3},   // R6 disp ignored
    {2'd0, 8'hC5, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF00, 8'd7},   // R3 R1 x8
    {2'd1, 8'h4D, 1'b0, 1'b1, 1'b1, 32'h1234_5680, 8'd11},  // R4 R13
    {2'd2, 8'h95, 1'b0, 1'b1, 1'b1, 32'h7FFF_0000, 8'd19},  // R5
    {2'd2, 8'hB3, 1'b1, 1'b1, 1'b1, 32'h8000_0004, 8'd23},  // R2 R5
    {2'd1, 8'h1F, 1'b1, 1'b1, 1'b0, 32'h0000_007F, 8'd29},  // R7 R2
    {2'd0, 8'hC4, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 8'd31},  // R7 wrap
    {2'd0, 8'hE5, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 8'd37},  // R3 R7
    {2'd2, 8'h7E, 1'b1, 1'b0, 1'b1, 32'h0000_0100, 8'd41},  // R5 R1
    {2'd1, 8'h02, 1'b0, 1'b0, 1'b0, 32'hABCD_EFFF, 8'd43}   // R4 R7
  };

  function automatic logic [31:0] lane_val(input logic [7:0] seed, input int k);
    return 32'(seed) * 32'h9E37_79B1 + 32'(k) * 32'h1F3D_5B79;
  endfunction

  function automatic logic [63:0] model(input logic [1:0] m, input logic [7:0] s,
      input logic b, input logic lm, input logic [31:0] d, input logic [31:0] iv);
    logic [3:0] bn;
    logic [63:0] bv, dv, sv, r;
    bn = {b & lm, s[2:0]};
    if (m == 2'd0 && s[2:0] == 3'b101) bv = '0;
    else bv = lm ? gpr[bn] : {32'h0, gpr[bn][31:0]};
    if (m == 2'd1) dv = {{56{d[7]}}, d[7:0]};
    else if (m == 2'd2 || (m == 2'd0 && s[2:0] == 3'b101)) dv = {{32{d[31]}}, d};
    else dv = '0;
    sv = {{32{iv[31]}}, iv} * (64'd1 << s[7:6]);
    r = bv + dv + sv;
    if (!lm) r = {32'h0, r[31:0]};
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [52:0] v);
    @(negedge clk);
    mod_f = v[52:51]; sib = v[50:43]; ext_x = v[42]; ext_b = v[41];
    long_mode = v[40]; disp = v[39:8];
    for (int k = 0; k < LANES; k++) vidx[k*32 +: 32] = lane_val(v[7:0], k);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] last0;
    for (int i = 0; i < 16; i++)
      gpr[i] = 64'hF000_0000_8000_0000 + 64'(i) * 64'h0000_0101_1000_1010;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {63'h0, out_valid}, 64'h0);
    check("R10 bad_enc", {63'h0, bad_enc}, 64'h0);
    check("R10 lane0", lane_addr[63:0], 64'h0);
    check("R10 lane7", lane_addr[511:448], 64'h0);
    rst_n = 1'b1;

    for (int t = 0; t < NV; t++) begin
      logic [52:0] v;
      v = TAB[t];
      run_op(v);
      check("R9 out_valid", {63'h0, out_valid}, 64'h1);
      check("R8 bad_enc low", {63'h0, bad_enc}, 64'h0);
      check("R2 base_sel", {60'h0, base_sel}, {60'h0, v[41] & v[40], v[45:43]});
      check("R2 index_sel", {60'h0, index_sel}, {60'h0, v[42] & v[40], v[48:46]});
      for (int k = 0; k < LANES; k++)
        check($sformatf("R1 R3-R7 vec%0d lane%0d", t, k), lane_addr[k*64 +: 64],
              model(v[52:51], v[50:43], v[41], v[40], v[39:8], lane_val(v[7:0], k)));
    end

    // R9 hold: change fields with in_valid low
    last0 = model(TAB[NV-1][52:51], TAB[NV-1][50:43], TAB[NV-1][41], TAB[NV-1][40],
                  TAB[NV-1][39:8], lane_val(TAB[NV-1][7:0], 0));
    @(negedge clk);
    mod_f = 2'd2; sib = 8'hFF; disp = 32'h5555_5555; long_mode = 1'b1; vidx = '1;
    @(negedge clk);
    check("R9 hold valid low", {63'h0, out_valid}, 64'h0);
    check("R9 hold lane0", lane_addr[63:0], last0);

    // R8 illegal encoding
    run_op({2'd3, 8'hC5, 1'b1, 1'b1, 1'b1, 32'h1111_1111, 8'd5});
    check("R8 out_valid", {63'h0, out_valid}, 64'h1);
    check("R8 bad_enc", {63'h0, bad_enc}, 64'h1);
    check("R8 lanes zero", {63'h0, |lane_addr}, 64'h0);

    // R1 scale x2 with negative index, R4 disp upper bits ignored
    run_op({2'd1, 8'h40, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF05, 8'd1});
    for (int k = 0; k < LANES; k++)
      check("R1 R4 scale2", lane_addr[k*64 +: 64],
            model(2'd1, 8'h40, 1'b0, 1'b1, 32'h0000_0005, lane_val(8'd1, k)));
    check("R8 bad_enc cleared", {63'h0, bad_enc}, 64'h0);

    finish_run();
  end
endmodule